// File: doc/BRIEF.md
# Polarity-Invertible GPIO Register Bank

This block is the register core of a small general-purpose I/O expander. A serial register front end, which is not part of this block, presents a two-bit register index, a write strobe with a data byte and a read strobe. The bank holds four registers: a read-only input view of the pins, an output latch, a per-pin polarity mask and a per-pin direction mask. It drives per-pin output-enable and output-value buses toward the pad ring and returns a read byte for the register selected by the index.

A direction bit of 1 leaves a pin undriven as an input and a 0 makes it an output. The input register has no storage of its own. It is the already-synchronised pin level, taken on the read strobe and flipped bit by bit where the polarity mask is set. A read of the output latch returns what was written, whatever the pin actually shows. Only the low four bits of a written byte are kept, and the upper half of every read byte is a constant fill.

Top module: `gpio_pol_bank`

## Requirements
- R1: After reset the direction register reads 0xFF, the output latch reads 0xFF, the polarity mask reads 0x00, pinOe and pinOut are all zero, and rdData is 0x00.
- R2: Register index encoding is 0 = input view, 1 = output latch, 2 = polarity mask, 3 = direction. A read strobe in cycle N loads rdData at that clock edge, so the value is visible in cycle N+1. Bits 7:4 of the read byte are 0000 for index 2 and 1111 for indices 0, 1 and 3.
- R3: A read of index 0 returns in bits 3:0 the pin levels sampled at the read edge XOR the polarity mask, whatever the direction of each pin.
- R4: A write to index 0 changes no register and no pin output.
- R5: A read of index 1 returns the stored latch bits, not the pin levels.
- R6: When direction bit i is 0, pinOe[i] is 1 and pinOut[i] equals latch bit i. When direction bit i is 1, pinOe[i] is 0 and pinOut[i] is 0, whatever the latch holds.
- R7: Bits 7:4 of written data are ignored. Only bits 3:0 are stored.
- R8: A write strobe updates the target register at the same clock edge. pinOe and pinOut follow one clock edge later.
- R9: rdData holds its value in every cycle without a read strobe, even when the pins change.
- R10: A read and a write of the same register in one cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regIdx | input | 2 | Register index for read and write |
| wrEn | input | 1 | Write strobe, one cycle per byte |
| wrData | input | 8 | Write data byte |
| rdEn | input | 1 | Read strobe, one cycle per byte |
| pinIn | input | 4 | Synchronised pin levels |
| pinOe | output | 4 | Per-pin output enable, 1 = drive |
| pinOut | output | 4 | Per-pin output value |
| rdData | output | 8 | Read data byte |

## Verification
On every cycle the assertions check the read-byte fill pattern for each index, the inverted input sample, latch read-back and rdData holding between strobes. They also check that the pin drive matches the registers one cycle late, using shadow copies built only from the write strobes. Reset defaults cannot be shown that way, and neither can the fact that a write to the input index leaves everything alone or that a same-cycle read returns the old value. The bench shows those in directed scenarios, alongside exhaustive sweeps of direction against latch value and of polarity against pin level.

// File: rtl/gpio_pol_pkg.sv
package gpio_pol_pkg;

  localparam int IDX_W = 2;

  typedef enum logic [IDX_W-1:0] {
    SEL_INPUT  = 2'd0,
    SEL_LATCH  = 2'd1,
    SEL_POLAR  = 2'd2,
    SEL_DIREC  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    wrLatch;
    logic    wrPolar;
    logic    wrDirec;
    logic    rdCapture;
    regSel_e rdSel;
  } bankStrobe_t;

endpackage

// File: rtl/gpio_pol_ctrl.sv
module gpio_pol_ctrl
  import gpio_pol_pkg::*;
(
  input  logic [IDX_W-1:0] regIdx,
  input  logic             wrEn,
  input  logic             rdEn,
  output bankStrobe_t      strobe
);

  regSel_e sel;

  assign sel = regSel_e'(regIdx);

  always_comb begin
    strobe           = '0;
    strobe.rdCapture = rdEn;
    strobe.rdSel     = sel;
    if (wrEn) begin
      unique case (sel)
        SEL_LATCH: strobe.wrLatch = 1'b1;
        SEL_POLAR: strobe.wrPolar = 1'b1;
        SEL_DIREC: strobe.wrDirec = 1'b1;
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_pol_dpath.sv
module gpio_pol_dpath
  import gpio_pol_pkg::*;
#(
  parameter int               PIN_W     = 4,
  parameter int               DATA_W    = 8,
  parameter logic [PIN_W-1:0] LATCH_RST = '1,
  parameter logic [PIN_W-1:0] DIREC_RST = '1
)(
  input  logic              clk,
  input  logic              rstN,
  input  bankStrobe_t       strobe,
  input  logic [PIN_W-1:0]  wrBits,
  input  logic [PIN_W-1:0]  pinIn,
  output logic [PIN_W-1:0]  pinOe,
  output logic [PIN_W-1:0]  pinOut,
  output logic [DATA_W-1:0] rdData
);

  localparam int PAD_W = DATA_W - PIN_W;

  logic [PIN_W-1:0]  latchReg;
  logic [PIN_W-1:0]  polarReg;
  logic [PIN_W-1:0]  direcReg;
  logic [DATA_W-1:0] rdNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchReg <= LATCH_RST;
      polarReg <= '0;
      direcReg <= DIREC_RST;
    end else begin
      if (strobe.wrLatch) latchReg <= wrBits;
      if (strobe.wrPolar) polarReg <= wrBits;
      if (strobe.wrDirec) direcReg <= wrBits;
    end
  end

  // Registered per-pin drive stage
  genvar gp;
  generate
    for (gp = 0; gp < PIN_W; gp++) begin : g_pin
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          pinOe[gp]  <= 1'b0;
          pinOut[gp] <= 1'b0;
        end else begin
          pinOe[gp]  <= ~direcReg[gp];
          pinOut[gp] <= latchReg[gp] & ~direcReg[gp];
        end
      end
    end
  endgenerate

  always_comb begin
    unique case (strobe.rdSel)
      SEL_INPUT: rdNext = {{PAD_W{1'b1}}, pinIn ^ polarReg};
      SEL_LATCH: rdNext = {{PAD_W{1'b1}}, latchReg};
      SEL_POLAR: rdNext = {{PAD_W{1'b0}}, polarReg};
      default:   rdNext = {{PAD_W{1'b1}}, direcReg};
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 rdData <= '0;
    else if (strobe.rdCapture) rdData <= rdNext;
  end

endmodule

// File: rtl/gpio_pol_bank.sv
module gpio_pol_bank
  import gpio_pol_pkg::*;
#(
  parameter int PIN_W  = 4,
  parameter int DATA_W = 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [PIN_W-1:0]  pinIn,
  output logic [PIN_W-1:0]  pinOe,
  output logic [PIN_W-1:0]  pinOut,
  output logic [DATA_W-1:0] rdData
);

  bankStrobe_t strobe;
  logic        unusedWrPad;

  assign unusedWrPad = ^wrData[DATA_W-1:PIN_W];

  gpio_pol_ctrl u_ctrl (
    .regIdx (regIdx),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .strobe (strobe)
  );

  gpio_pol_dpath #(
    .PIN_W  (PIN_W),
    .DATA_W (DATA_W)
  ) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrBits (wrData[PIN_W-1:0]),
    .pinIn  (pinIn),
    .pinOe  (pinOe),
    .pinOut (pinOut),
    .rdData (rdData)
  );

endmodule

// File: rtl/gpio_pol_chk.sv
module gpio_pol_chk #(
  parameter int PIN_W  = 4,
  parameter int DATA_W = 8
)(
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        regIdx,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic              rdEn,
  input logic [PIN_W-1:0]  pinIn,
  input logic [PIN_W-1:0]  pinOe,
  input logic [PIN_W-1:0]  pinOut,
  input logic [DATA_W-1:0] rdData
);

  localparam int PAD_W = DATA_W - PIN_W;

  logic [PIN_W-1:0] latchSh;
  logic [PIN_W-1:0] polarSh;
  logic [PIN_W-1:0] direcSh;
  logic             unusedChkPad;

  assign unusedChkPad = ^wrData[DATA_W-1:PIN_W];

  // Shadows built from the port-level write strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchSh <= '1;
      polarSh <= '0;
      direcSh <= '1;
    end else if (wrEn) begin
      if (regIdx == 2'd1) latchSh <= wrData[PIN_W-1:0];
      if (regIdx == 2'd2) polarSh <= wrData[PIN_W-1:0];
      if (regIdx == 2'd3) direcSh <= wrData[PIN_W-1:0];
    end
  end

  // R2
  polar_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regIdx == 2'd2) |=> rdData[DATA_W-1:PIN_W] == {PAD_W{1'b0}});

  // R2
  other_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regIdx != 2'd2) |=> rdData[DATA_W-1:PIN_W] == {PAD_W{1'b1}});

  // R3
  input_view_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regIdx == 2'd0) |=> rdData[PIN_W-1:0] == ($past(pinIn) ^ $past(polarSh)));

  // R5
  latch_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && regIdx == 2'd1) |=> rdData[PIN_W-1:0] == $past(latchSh));

  // R6
  drive_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    pinOe == ~$past(direcSh));

  // R6
  drive_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    pinOut == ($past(latchSh) & ~$past(direcSh)));

  // R9
  read_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

endmodule

bind gpio_pol_bank gpio_pol_chk #(
  .PIN_W  (PIN_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .regIdx (regIdx),
  .wrEn   (wrEn),
  .wrData (wrData),
  .rdEn   (rdEn),
  .pinIn  (pinIn),
  .pinOe  (pinOe),
  .pinOut (pinOut),
  .rdData (rdData)
);

// File: tb/gpio_pol_bank_bench.sv
module gpio_pol_bank_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regIdx = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       rdEn = 1'b0;
  logic [3:0] pinIn = '0;
  logic [3:0] pinOe;
  logic [3:0] pinOut;
  logic [7:0] rdData;

  int checkCnt = 0;
  int failCnt  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_pol_bank u_gpio_pol_bank (
    .clk    (clk),
    .rstN   (rstN),
    .regIdx (regIdx),
    .wrEn   (wrEn),
    .wrData (wrData),
    .rdEn   (rdEn),
    .pinIn  (pinIn),
    .pinOe  (pinOe),
    .pinOut (pinOut),
    .rdData (rdData)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [1:0] idx, input logic [7:0] data);
    @(negedge clk);
    regIdx = idx; wrData = data; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [1:0] idx, output logic [7:0] data);
    @(negedge clk);
    regIdx = idx; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    data = rdData;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic [3:0] oldDir;
    logic [3:0] polV;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pinOe", {4'h0, pinOe}, 8'h00);
    check("R1 pinOut", {4'h0, pinOut}, 8'h00);
    check("R1 rdData", rdData, 8'h00);
    doRead(2'd3, rd); check("R1 direction default", rd, 8'hFF);
    doRead(2'd1, rd); check("R1 latch default", rd, 8'hFF);
    doRead(2'd2, rd); check("R1 polarity default", rd, 8'h00);

    // R6 R8 R5 R7 sweep of direction against latch value
    oldDir = 4'hF;
    for (int d = 0; d < 16; d++) begin
      for (int o = 0; o < 16; o++) begin
        pinIn = ~o[3:0];
        doWrite(2'd1, {~o[3:0], o[3:0]});
        doWrite(2'd3, {o[3:0], d[3:0]});
        check("R8 pinOe lags", {4'h0, pinOe}, {4'h0, ~oldDir});
        check("R8 pinOut lags", {4'h0, pinOut}, {4'h0, o[3:0] & ~oldDir});
        @(negedge clk);
        check("R6 pinOe", {4'h0, pinOe}, {4'h0, ~d[3:0]});
        check("R6 pinOut", {4'h0, pinOut}, {4'h0, o[3:0] & ~d[3:0]});
        oldDir = d[3:0];
      end
      doRead(2'd1, rd); check("R5 R7 latch readback", rd, {4'hF, 4'hF});
      doRead(2'd3, rd); check("R7 direction readback", rd, {4'hF, d[3:0]});
    end
    doWrite(2'd1, 8'h0A);
    pinIn = 4'h5;
    doRead(2'd1, rd); check("R5 latch not pin", rd, 8'hFA);

    // R3 sweep of polarity against pin level, mixed directions
    doWrite(2'd3, 8'h05);
    for (int p = 0; p < 16; p++) begin
      doWrite(2'd2, {4'hA, p[3:0]});
      doRead(2'd2, rd); check("R2 R7 polarity readback", rd, {4'h0, p[3:0]});
      for (int n = 0; n < 16; n++) begin
        pinIn = n[3:0];
        doRead(2'd0, rd);
        check("R3 input view", rd, {4'hF, n[3:0] ^ p[3:0]});
      end
    end

    // R9 hold while pins move
    pinIn = 4'h3;
    doRead(2'd0, rd);
    pinIn = 4'hC;
    repeat (3) @(negedge clk);
    check("R9 hold", rdData, rd);

    // R4 write to input index
    doWrite(2'd0, 8'h00);
    doWrite(2'd0, 8'hFF);
    @(negedge clk);
    doRead(2'd1, rd); check("R4 latch unchanged", rd, 8'hFA);
    doRead(2'd2, rd); check("R4 polarity unchanged", rd, 8'h0F);
    doRead(2'd3, rd); check("R4 direction unchanged", rd, 8'hF5);
    check("R4 pinOe unchanged", {4'h0, pinOe}, 8'h0A);
    check("R4 pinOut unchanged", {4'h0, pinOut}, 8'h0A);

    // R10 read and write same register in one cycle
    polV = 4'h6;
    @(negedge clk);
    regIdx = 2'd2; wrData = {4'h0, polV}; wrEn = 1'b1; rdEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    check("R10 old value", rdData, 8'h0F);
    doRead(2'd2, rd); check("R10 new value", rd, {4'h0, polV});

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule